// File: doc/BRIEF.md
# Receiver Idle Time-out Counter

This block sits beside the receive path of a UART running as a LIN slave and decides when the bus has gone quiet long enough for the node to sleep. Software programs a 17-bit idle limit counted in bit periods. Each received character reloads a down-counter with that limit. Each bit-period tick takes one off the count. When the count runs out, a sticky time-out flag rises, and it can raise an interrupt.

Two commands choose how counting resumes. The wait command loads the limit and freezes the counter until the next character arrives. The restart command loads the limit and counts from it straight away. A limit of zero turns the function off. For reference, LIN 1.3 sets the idle limit at 25000 bit times, and LIN 2.0 sets it at four seconds of wall time.

Top module: `rx_idle_timeout`

## Requirements
- R1: After reset, `timeout_flag` and `irq` are 0. The counter stays frozen until a character is received, so ticks alone never set the flag.
- R2: While `to_value` is 0, `timeout_flag` never rises, however many ticks arrive.
- R3: Once the counter is running from a load of N (N ≥ 1), `timeout_flag` is still 0 after N−1 ticks. It reads 1 in the cycle after the edge that takes the N-th tick.
- R4: A `char_rx` pulse loads `to_value` and starts the count. Ticks counted before the pulse do not carry over.
- R5: A `cmd_wait_char` pulse loads `to_value` and freezes the counter. Ticks have no effect until the next `char_rx`. After that character, expiry takes N more ticks.
- R6: A `cmd_restart` pulse loads `to_value` and counts at once, so N ticks after it set the flag without any character.
- R7: `timeout_flag` stays set until a `cmd_clr_status` pulse. If a set and a clear fall in the same cycle, the set wins.
- R8: After expiry the counter holds at 0 and does not wrap. After a clear, further ticks do not set the flag again until a reload and a fresh expiry.
- R9: `irq` equals `timeout_flag` AND `irq_en`.
- R10: When `char_rx` and `bit_tick` arrive in the same cycle, the reload wins and the tick is lost.
- R11: Commands rank in this order: `cmd_restart`, then `cmd_wait_char`, then `char_rx`. Of any that arrive together, only the highest-ranked one takes effect.
- R12: The full 17-bit limit is honoured. A load of 131071 expires only after 131071 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| to_value | input | 17 | Idle limit in bit periods; 0 disables |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| char_rx | input | 1 | One-cycle pulse per received character |
| cmd_wait_char | input | 1 | Load the limit and freeze until the next character |
| cmd_restart | input | 1 | Load the limit and count at once |
| cmd_clr_status | input | 1 | Clear the sticky time-out flag |
| irq_en | input | 1 | Interrupt enable |
| timeout_flag | output | 1 | Sticky idle time-out status |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is an expiry at the edge of the count. The flag must stay low after exactly N−1 ticks and rise on the N-th, and this must hold for every load path: a character, the restart command, and a wait followed by a character. The bench sweeps N from 1 to 12 through each path, sampling between ticks. It repeats the sweep with a reload landing in the same cycle as a tick, and with commands that collide. A single run at the 17-bit maximum, with a tick on every cycle, confirms that no bit of the limit is dropped.

// File: rtl/rx_idle_timeout.sv
module rx_idle_timeout #(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] to_value,
  input  logic             bit_tick,
  input  logic             char_rx,
  input  logic             cmd_wait_char,
  input  logic             cmd_restart,
  input  logic             cmd_clr_status,
  input  logic             irq_en,
  output logic             timeout_flag,
  output logic             irq
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             enabled, dec, expire;

  assign enabled = |to_value;
  assign dec     = run_q && bit_tick && (cnt_q != '0) &&
                   !cmd_restart && !cmd_wait_char && !char_rx;
  assign expire  = dec && enabled && (cnt_q == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (cmd_restart) begin
      cnt_q <= to_value;
      run_q <= 1'b1;
    end else if (cmd_wait_char) begin
      cnt_q <= to_value;
      run_q <= 1'b0;
    end else if (char_rx) begin
      cnt_q <= to_value;
      run_q <= 1'b1;
    end else if (dec) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              timeout_flag <= 1'b0;
    else if (expire)         timeout_flag <= 1'b1;
    else if (cmd_clr_status) timeout_flag <= 1'b0;
  end

  assign irq = timeout_flag & irq_en;

endmodule

module rx_idle_timeout_chk #(
  parameter int CNT_W = 17
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] to_value,
  input logic             bit_tick,
  input logic             char_rx,
  input logic             cmd_wait_char,
  input logic             cmd_restart,
  input logic             cmd_clr_status,
  input logic             timeout_flag,
  input logic [CNT_W-1:0] cnt_q,
  input logic             run_q
);

  assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_flag) |-> $past(to_value) != '0);

  assert_rise_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_flag) |-> $past(bit_tick) && $past(run_q));

  assert_char_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (char_rx && !cmd_restart && !cmd_wait_char) |=> (cnt_q == $past(to_value)) && run_q);

  assert_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !char_rx && !cmd_restart && !cmd_wait_char) |=> $stable(cnt_q) && !run_q);

  assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_restart |=> (cnt_q == $past(to_value)) && run_q);

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_flag && !cmd_clr_status) |=> timeout_flag);

  assert_hold_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !char_rx && !cmd_restart && !cmd_wait_char) |=> cnt_q == '0);

endmodule

bind rx_idle_timeout rx_idle_timeout_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .to_value(to_value), .bit_tick(bit_tick),
  .char_rx(char_rx), .cmd_wait_char(cmd_wait_char), .cmd_restart(cmd_restart),
  .cmd_clr_status(cmd_clr_status), .timeout_flag(timeout_flag),
  .cnt_q(cnt_q), .run_q(run_q));

// File: tb/rx_idle_timeout_tb_top.sv
module rx_idle_timeout_tb_top;
  logic clk = 0, rst_n = 0;
  logic [16:0] to_value = '0;
  logic bit_tick = 0, char_rx = 0, cmd_wait_char = 0, cmd_restart = 0;
  logic cmd_clr_status = 0, irq_en = 0;
  logic timeout_flag, irq;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rx_idle_timeout dut_i (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic cyc(input logic t, input logic c, input logic w = 0,
                     input logic r = 0, input logic cl = 0);
    @(negedge clk);
    bit_tick = t; char_rx = c; cmd_wait_char = w; cmd_restart = r; cmd_clr_status = cl;
    @(negedge clk);
    bit_tick = 0; char_rx = 0; cmd_wait_char = 0; cmd_restart = 0; cmd_clr_status = 0;
  endtask

  task automatic ticks(input int k);
    for (int i = 0; i < k; i++) cyc(1, 0);
  endtask

  task automatic clr();
    cyc(0, 0, 0, 0, 1);
  endtask

  initial begin
    #4_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1", timeout_flag, 0);
    chk("R1", irq, 0);
    to_value = 17'd5;
    ticks(20);
    chk("R1", timeout_flag, 0);

    // R3/R4 sweep via character
    for (int n = 1; n <= 12; n++) begin
      to_value = 17'(n);
      clr();
      cyc(0, 1);
      ticks(n - 1);
      chk("R3", timeout_flag, 0);
      ticks(1);
      chk("R3", timeout_flag, 1);
    end

    // R4: pre-character ticks don't carry
    to_value = 17'd6; clr();
    cyc(0, 1); ticks(4); cyc(0, 1); ticks(5);
    chk("R4", timeout_flag, 0);
    ticks(1);
    chk("R4", timeout_flag, 1);

    // R6 restart sweep
    for (int n = 1; n <= 12; n++) begin
      to_value = 17'(n);
      clr();
      cyc(0, 0, 1);
      ticks(3 * n);
      cyc(0, 0, 0, 1);
      ticks(n - 1);
      chk("R6", timeout_flag, 0);
      ticks(1);
      chk("R6", timeout_flag, 1);
    end

    // R5 wait-for-character sweep
    for (int n = 1; n <= 12; n++) begin
      to_value = 17'(n);
      clr();
      cyc(0, 1);
      cyc(0, 0, 1);
      ticks(3 * n + 2);
      chk("R5", timeout_flag, 0);
      cyc(0, 1);
      ticks(n - 1);
      chk("R5", timeout_flag, 0);
      ticks(1);
      chk("R5", timeout_flag, 1);
    end

    // R10 reload wins over tick
    for (int n = 1; n <= 6; n++) begin
      to_value = 17'(n);
      clr();
      cyc(0, 1);
      ticks(n - 1);
      cyc(1, 1);
      ticks(n - 1);
      chk("R10", timeout_flag, 0);
      ticks(1);
      chk("R10", timeout_flag, 1);
    end

    // R11 priority: restart beats wait; wait beats char
    to_value = 17'd3; clr();
    cyc(0, 1, 1, 1); ticks(3);
    chk("R11", timeout_flag, 1);
    clr();
    cyc(0, 1, 1, 0); ticks(9);
    chk("R11", timeout_flag, 0);

    // R8 hold at zero, no reassert after clear
    to_value = 17'd2; cyc(0, 1); ticks(2);
    chk("R8", timeout_flag, 1);
    clr();
    chk("R7", timeout_flag, 0);
    ticks(40);
    chk("R8", timeout_flag, 0);

    // R7 sticky and set beats clear
    cyc(0, 1); ticks(2); ticks(10);
    chk("R7", timeout_flag, 1);
    cyc(0, 1); ticks(1); cyc(1, 0, 0, 0, 1);
    chk("R7", timeout_flag, 1);

    // R9 interrupt gating
    irq_en = 0; #1 chk("R9", irq, 0);
    irq_en = 1; #1 chk("R9", irq, 1);
    clr(); chk("R9", irq, 0);
    irq_en = 0;

    // R2 disable
    to_value = '0; clr();
    cyc(0, 1); ticks(40);
    chk("R2", timeout_flag, 0);
    cyc(0, 0, 0, 1); ticks(40);
    chk("R2", timeout_flag, 0);

    // R12 full width
    to_value = 17'h1FFFF; clr();
    cyc(0, 1);
    @(negedge clk); bit_tick = 1;
    repeat (131070) @(negedge clk);
    bit_tick = 0;
    chk("R12", timeout_flag, 0);
    ticks(1);
    chk("R12", timeout_flag, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    done = 1;
    $finish;
  end
endmodule